// File: doc/BRIEF.md
# Interval Timer with Square-Wave Output

This block is an up-counter that divides a prescaled count clock into a fixed interval. A compare value sets that interval: each time the counter meets the compare value on a count-clock strobe, the counter restarts from zero, a square-wave output flips its level and a one-cycle interrupt pulse goes out. The output therefore runs at half the interval rate, which makes it usable as a programmable square-wave source as well as a periodic interrupt source.

Everything runs on the system clock. The count clock arrives as a single-cycle strobe from an external prescaler, and the counter moves only on cycles where that strobe is high. An enable input starts and stops the timer; dropping it stops the count and returns both outputs to their idle state, where the square-wave output rests at a level chosen by a static input. The compare value is read directly from its input port on every comparison, so software may change it at any time.

Top module: `itv_timer`

## Requirements
- R1: After synchronous reset the square-wave output equals `idle_lvl`, the interrupt is low and the counter is at 0, so the first interrupt after enabling comes after exactly `cmp_val`+1 strobes.
- R2: While enabled, the counter moves only on cycles where `cnt_tick` is 1; cycles without the strobe change neither the count nor the outputs.
- R3: When `cnt_tick` is 1 and the counter equals `cmp_val`, the counter returns to 0 at that edge, so with a constant compare value successive interrupts are exactly `cmp_val`+1 strobes apart.
- R4: `sq_out` inverts at every match and at no other time while enabled.
- R5: `irq` is 1 for exactly the one system-clock cycle that follows each match edge and 0 on every other cycle.
- R6: One cycle after `run_en` is 0, `sq_out` equals `idle_lvl`, `irq` is 0 and the counter is 0; if the output already sat at the idle level it stays there with no glitch.
- R7: On re-enable the count restarts from 0, and the first interrupt arrives after `cmp_val`+1 strobes.
- R8: A new `cmp_val` applied while running is used at the very next comparison; if it lies below the current count, the counter runs up through 255, wraps to 0 and matches on the way back up.
- R9: `cmp_val` of 255 gives an interval of 256 strobes; `cmp_val` of 0 gives an interrupt on every strobe.
- R10: While disabled, a change of `idle_lvl` appears on `sq_out` one system-clock cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_tick | input | 1 | Count-clock strobe, one system cycle wide per count clock |
| run_en | input | 1 | 1 runs the timer, 0 stops it and returns outputs to idle |
| cmp_val | input | 8 | Compare value; interval is cmp_val+1 strobes |
| idle_lvl | input | 1 | Level of sq_out at reset and while stopped |
| irq | output | 1 | Interrupt pulse, one system cycle per match |
| sq_out | output | 1 | Square-wave output, toggles on each match |

## Verification
The hardest case to reach from the ports is a compare value lowered below the live count, which forces the counter to run up through 255 and wrap before it can match. The stimulus gets there by advancing the counter a known number of strobes under one compare value, then writing a smaller one and counting the strobes to the next interrupt (251 in the directed case). A reference model in the bench follows every cycle of the directed cases and of a long random phase with irregular strobes, random compare rewrites and random enable drops, so wraps and mid-interval disables also occur unplanned.

// File: rtl/itv_pkg.sv
package itv_pkg;

    localparam int CNT_W = 8;

    // Output state of the wave stage
    typedef struct packed {
        logic sq;
        logic irq;
    } wave_t;

    // Next output state; stop forces idle, a match flips the wave and pulses irq
    function automatic wave_t wave_next(wave_t cur, logic run, logic hit, logic idle);
        wave_t nx;
        if (!run) begin
            nx.sq  = idle;
            nx.irq = 1'b0;
        end else begin
            nx.sq  = hit ? ~cur.sq : cur.sq;
            nx.irq = hit;
        end
        return nx;
    endfunction

endpackage

// File: rtl/itv_count.sv
module itv_count #(
    parameter int W = itv_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         hit
);

    logic [W-1:0] count_q;

    assign hit = run && tick && (count_q == limit);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= hit ? '0 : count_q + 1'b1;
        end
    end

    // R2: no strobe, no movement
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (run && !tick) |=> $stable(count_q));

    // R3: a match returns the counter to zero
    assert_clear_R3: assert property (@(posedge clk) disable iff (rst)
        hit |=> (count_q == '0));

    // R8: a non-matching strobe advances by one (wrap included)
    assert_step_R8: assert property (@(posedge clk) disable iff (rst)
        (run && tick && !hit) |=> (count_q == W'($past(count_q) + 1'b1)));

    // R6: stopping parks the counter at zero
    assert_park_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (count_q == '0));

endmodule

// File: rtl/itv_wave.sv
module itv_wave
    import itv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic hit,
    input  logic idle,
    output logic sq,
    output logic irq
);

    wave_t st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.sq  <= idle;
            st_q.irq <= 1'b0;
        end else begin
            st_q <= wave_next(st_q, run, hit, idle);
        end
    end

    assign sq  = st_q.sq;
    assign irq = st_q.irq;

    // R4: each match flips the wave
    assert_flip_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (sq != $past(sq)));

    // R4: without a match the running wave keeps its level
    assert_keep_R4: assert property (@(posedge clk) disable iff (rst)
        (run && !hit) |=> $stable(sq));

    // R5: interrupt follows matches cycle for cycle
    assert_irq_hit_R5: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq);
    assert_irq_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        !hit |=> !irq);

    // R6 / R10: stopped timer shows the idle level
    assert_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !run |=> (sq == $past(idle)) && !irq);

endmodule

// File: rtl/itv_timer.sv
module itv_timer #(
    parameter int W = itv_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_tick,
    input  logic         run_en,
    input  logic [W-1:0] cmp_val,
    input  logic         idle_lvl,
    output logic         irq,
    output logic         sq_out
);

    logic hit;

    itv_count #(.W(W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .run   (run_en),
        .tick  (cnt_tick),
        .limit (cmp_val),
        .hit   (hit)
    );

    itv_wave u_wave (
        .clk  (clk),
        .rst  (rst),
        .run  (run_en),
        .hit  (hit),
        .idle (idle_lvl),
        .sq   (sq_out),
        .irq  (irq)
    );

    // R1: after reset, outputs rest at idle
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (sq_out == $past(idle_lvl)) && !irq);

endmodule

// File: tb/sim_itv_timer.sv
module sim_itv_timer;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_tick = 1'b0;
    logic       run_en = 1'b0;
    logic [7:0] cmp_val = 8'd0;
    logic       idle_lvl = 1'b1;
    logic       irq;
    logic       sq_out;

    int vectors = 0;
    int misses  = 0;
    int cycles  = 0;
    string tag  = "R1";

    // reference state
    logic [7:0] m_cnt = 8'd0;
    logic       m_sq  = 1'b1;
    logic       m_irq = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    itv_timer u0 (
        .clk      (clk),
        .rst      (rst),
        .cnt_tick (cnt_tick),
        .run_en   (run_en),
        .cmp_val  (cmp_val),
        .idle_lvl (idle_lvl),
        .irq      (irq),
        .sq_out   (sq_out)
    );

    function automatic logic [7:0] ref_cnt(logic [7:0] c, logic r, logic t, logic [7:0] k);
        if (!r) return 8'd0;
        if (!t) return c;
        return (c == k) ? 8'd0 : c + 8'd1;
    endfunction

    function automatic logic ref_match(logic [7:0] c, logic r, logic t, logic [7:0] k);
        return r && t && (c == k);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 8'd0;
            m_sq  <= idle_lvl;
            m_irq <= 1'b0;
        end else begin
            m_cnt <= ref_cnt(m_cnt, run_en, cnt_tick, cmp_val);
            m_irq <= ref_match(m_cnt, run_en, cnt_tick, cmp_val);
            m_sq  <= !run_en ? idle_lvl :
                     (ref_match(m_cnt, run_en, cnt_tick, cmp_val) ? ~m_sq : m_sq);
        end
    end

    task automatic report;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    task automatic check(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d at t=%0t", req, act, exp, $time);
        end
    endtask

    // one system cycle; inputs already set, sampled at the following negedge
    task automatic cyc(input logic t);
        cnt_tick = t;
        @(posedge clk);
        @(negedge clk);
        cycles++;
        check({tag, " sq_out"}, int'(sq_out), int'(m_sq));
        check({tag, " irq"}, int'(irq), int'(m_irq));
    endtask

    task automatic ticks_to_irq(output int n);
        n = 0;
        do begin
            cyc(1'b1);
            n++;
        end while (!irq && n < 400);
        cnt_tick = 1'b0;
    endtask

    initial begin
        int n;
        logic s0;
        void'($urandom(32'd1234));

        @(negedge clk);
        cyc(1'b0);
        cyc(1'b0);
        rst = 1'b0;
        cyc(1'b0);
        // R1: reset state
        check("R1 reset sq", int'(sq_out), 1);
        check("R1 reset irq", int'(irq), 0);

        // R1/R3/R4: first and second interval with cmp 5
        tag = "R3";
        cmp_val = 8'd5;
        run_en = 1'b1;
        ticks_to_irq(n);
        check("R1 first interval", n, 6);
        check("R4 sq after first match", int'(sq_out), 0);
        cyc(1'b0);
        check("R5 irq one cycle", int'(irq), 0);
        ticks_to_irq(n);
        check("R3 second interval", n, 6);
        check("R4 sq after second match", int'(sq_out), 1);

        // R2: gaps between strobes do not advance
        tag = "R2";
        for (int i = 0; i < 3; i++) cyc(1'b1);
        for (int i = 0; i < 10; i++) cyc(1'b0);
        ticks_to_irq(n);
        check("R2 remaining strobes", n, 3);

        // R9: extremes of compare
        tag = "R9";
        cmp_val = 8'hFF;
        ticks_to_irq(n);
        check("R9 interval 256", n, 256);
        cmp_val = 8'h00;
        ticks_to_irq(n);
        check("R9 cmp 0 interval", n, 1);
        cyc(1'b1);
        check("R9 cmp 0 back-to-back irq", int'(irq), 1);
        cyc(1'b0);

        // R8: compare rewritten while running
        tag = "R8";
        cmp_val = 8'd20;
        for (int i = 0; i < 10; i++) cyc(1'b1);
        cmp_val = 8'd15;
        ticks_to_irq(n);
        check("R8 raised-limit interval", n, 6);
        cmp_val = 8'd30;
        for (int i = 0; i < 10; i++) cyc(1'b1);
        cmp_val = 8'd4;
        ticks_to_irq(n);
        check("R8 wrap interval", n, 251);

        // R6: stop mid-interval
        tag = "R6";
        for (int i = 0; i < 2; i++) cyc(1'b1);
        run_en = 1'b0;
        cyc(1'b1);
        check("R6 sq idle after stop", int'(sq_out), int'(idle_lvl));
        check("R6 irq low after stop", int'(irq), 0);
        for (int i = 0; i < 8; i++) cyc(1'b1);
        check("R6 no irq while stopped", int'(irq), 0);

        // R10: idle level follows input while stopped
        tag = "R10";
        idle_lvl = 1'b0;
        cyc(1'b0);
        check("R10 idle change", int'(sq_out), 0);

        // R7: restart from zero
        tag = "R7";
        cmp_val = 8'd3;
        run_en = 1'b1;
        ticks_to_irq(n);
        check("R7 restart interval", n, 4);

        // R6: stop while already at idle level
        tag = "R6";
        ticks_to_irq(n);
        s0 = sq_out;
        check("R6 sq back at idle before stop", int'(s0), 0);
        run_en = 1'b0;
        cyc(1'b0);
        check("R6 idle held", int'(sq_out), 0);

        // random phase, checked against the model every cycle
        tag = "R4/R5 random";
        run_en = 1'b1;
        for (int i = 0; i < 6000; i++) begin
            if (($urandom % 40) == 0) cmp_val = 8'($urandom % 12);
            if (($urandom % 500) == 0) cmp_val = 8'($urandom);
            if (($urandom % 150) == 0) run_en = ~run_en;
            if (!run_en && ($urandom % 20) == 0) idle_lvl = ~idle_lvl;
            cyc(1'(($urandom % 3) != 0));
        end
        report();
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > WATCHDOG) begin
                misses++;
                $display("FAIL watchdog: actual %0d cycles expected under %0d", cycles, WATCHDOG);
                report();
            end
        end
    end

endmodule